// File: doc/BRIEF.md
# SPI Transmit Serial CRC Accumulator

This block keeps a running CRC over the bits that an SPI transmitter puts on the wire. The transmit shifter pulses a bit strobe once per serialized bit while it holds the current frame word on a parallel input. The accumulator tracks the bit position inside the frame itself and picks the outgoing bit in wire order, MSB-first or LSB-first. It then folds that bit into the CRC state in the same clock edge. The CRC therefore moves bit by bit, and a read in the middle of a frame returns a partial value.

The CRC width follows the frame size. An 8-bit frame gives an 8-bit CRC and a 16-bit frame gives a 16-bit CRC, both built from a programmable polynomial. Any other frame size freezes the accumulator. Raising the CRC enable from 0 to 1 clears the state, and so does a soft clear pulse. The result is always visible on a 32-bit read word.

Top module: `spi_tx_crc_acc`

## Requirements
- R1: After the synchronous active-low reset, `rd_data` reads 0.
- R2: With `frm_len_m1` = 7 (8-bit frames), the CRC is 8 bits wide in `rd_data[7:0]`, and `rd_data[15:8]` stays 0.
- R3: With `frm_len_m1` = 15 (16-bit frames), the CRC is 16 bits wide in `rd_data[15:0]`.
- R4: `rd_data[31:16]` always reads 0.
- R5: Each accepted bit b updates the state one clock later: fb = b XOR crc[top], then crc = (crc << 1) XOR (fb ? poly : 0), masked to the active width. The partial value is readable after every bit.
- R6: With `lsb_first` = 0, the bits of a frame are taken from `frm_word[len-1]` down to `frm_word[0]`. With `lsb_first` = 1, they are taken from `frm_word[0]` upward. The bit position returns to the first bit after the last bit of a frame, so the same word sent in the two orders gives different CRCs.
- R7: A 0-to-1 change of `crc_en` clears the CRC and the bit position, and a `soft_clr` pulse does the same.
- R8: For any `frm_len_m1` other than 7 or 15, strobes leave the CRC unchanged.
- R9: While `crc_en` is 0, `bit_vld` is ignored and the CRC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crc_en | input | 1 | CRC enable; a rising level clears the state |
| soft_clr | input | 1 | One-cycle clear of the CRC and the bit position |
| bit_vld | input | 1 | One pulse per bit shifted onto the wire |
| frm_word | input | 16 | Frame word currently being shifted |
| frm_len_m1 | input | 4 | Frame length minus one (7 or 15 supported) |
| lsb_first | input | 1 | 1: LSB goes first on the wire, 0: MSB goes first |
| poly | input | 16 | CRC polynomial (bits [7:0] used in 8-bit mode) |
| rd_data | output | 32 | Read word: CRC in the low bits, zero above |

## Verification
The bench builds the block with its default parameters: a 16-bit CRC state and a 32-bit read word. These defaults let both frame sizes and the always-zero upper half of the read word be checked. Random frames in both orders run under polynomials 0x0007 and 0x8005, and every partial CRC is compared with a bitwise model after each bit. The bench also covers a re-enable in the middle of a frame, unsupported frame lengths, and strobes sent while the enable is low.

// File: rtl/spi_crc_pkg.sv
// Package: shared width decode for the transmit CRC accumulator.
// Assumes frame length is presented as length minus one on four bits.
package spi_crc_pkg;
    typedef enum logic [1:0] {
        WID_NONE = 2'd0,
        WID_8    = 2'd1,
        WID_16   = 2'd2
    } crc_wid_e;

    // Map a frame length (minus one) to the CRC width it selects.
    function automatic crc_wid_e decode_wid(input logic [3:0] len_m1);
        case (len_m1)
            4'd7:    return WID_8;
            4'd15:   return WID_16;
            default: return WID_NONE;
        endcase
    endfunction
endpackage

// File: rtl/spi_crc_bitsel.sv
// Bit picker: tracks the position inside the frame and selects the bit
// that is on the wire, honouring the first-bit order.
// Assumes adv is only raised for a supported width.
module spi_crc_bitsel
    import spi_crc_pkg::*;
#(
    parameter int MAXF = 16,
    localparam int PW  = $clog2(MAXF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    input  crc_wid_e        wid,
    input  logic            lsb_first,
    input  logic [MAXF-1:0] frm_word,
    output logic            wire_bit
);
    logic [PW-1:0] pos;
    logic [PW-1:0] last;
    logic [PW-1:0] idx;

    // Last bit index of the current frame size.
    always_comb begin
        last = (wid == WID_16) ? PW'(MAXF - 1) : PW'(MAXF / 2 - 1);
        idx  = lsb_first ? pos : PW'(last - pos);
        wire_bit = frm_word[idx];
    end

    // Position counter: advances per bit, wraps at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pos <= '0;
        else if (adv)
            pos <= (pos == last) ? '0 : PW'(pos + 1'b1);
    end

    // R6: after the last bit of a frame the next bit is the first one.
    assert_pos_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && pos == last) |=> (pos == '0));
endmodule

// File: rtl/spi_crc_core.sv
// Serial CRC core: folds one bit per accepted strobe into the state,
// with the active width chosen per step (half or full).
// Assumes clr has priority over adv.
module spi_crc_core
    import spi_crc_pkg::*;
#(
    parameter int W  = 16,
    localparam int HW = W / 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic         bit_in,
    input  crc_wid_e     wid,
    input  logic [W-1:0] poly,
    output logic [W-1:0] state
);
    logic [W-1:0] nxt;
    logic         fb;

    // Next-state computation for the selected width.
    always_comb begin
        if (wid == WID_16) begin
            fb  = bit_in ^ state[W-1];
            nxt = {state[W-2:0], 1'b0} ^ (fb ? poly : '0);
        end else begin
            fb  = bit_in ^ state[HW-1];
            nxt = {{HW{1'b0}}, state[HW-2:0], 1'b0}
                ^ (fb ? {{HW{1'b0}}, poly[HW-1:0]} : '0);
        end
    end

    // State register: clear, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            state <= '0;
        else if (adv)
            state <= nxt;
    end

    // R7: a clear leaves a zero state.
    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state == '0));
    // R8/R9: without an accepted bit the state holds.
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(state));
    // R2: an 8-bit step keeps the upper half zero.
    assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && wid == WID_8) |=> (state[W-1:HW] == '0));
endmodule

// File: rtl/spi_tx_crc_acc.sv
// Top: transmit-side serial CRC accumulator with a plain read word.
// Detects the enable rising edge, gates strobes, and joins the bit
// picker to the CRC core. Assumes one bit_vld pulse per wire bit.
module spi_tx_crc_acc
    import spi_crc_pkg::*;
#(
    parameter int CRC_W = 16,
    parameter int RD_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crc_en,
    input  logic             soft_clr,
    input  logic             bit_vld,
    input  logic [CRC_W-1:0] frm_word,
    input  logic [3:0]       frm_len_m1,
    input  logic             lsb_first,
    input  logic [CRC_W-1:0] poly,
    output logic [RD_W-1:0]  rd_data
);
    logic             en_q;
    logic             en_rise;
    logic             clr;
    logic             adv;
    logic             wire_bit;
    crc_wid_e         wid;
    logic [CRC_W-1:0] state;

    // Remember the enable level to spot a 0-to-1 write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else
            en_q <= crc_en;
    end

    // Clear, width and acceptance decode.
    always_comb begin
        en_rise = crc_en & ~en_q;
        clr     = en_rise | soft_clr;
        wid     = decode_wid(frm_len_m1);
        adv     = bit_vld & crc_en & (wid != WID_NONE);
        rd_data = {{(RD_W - CRC_W){1'b0}}, state};
    end

    spi_crc_bitsel #(.MAXF(CRC_W)) u_bitsel (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .wid(wid),
        .lsb_first(lsb_first), .frm_word(frm_word), .wire_bit(wire_bit)
    );

    spi_crc_core #(.W(CRC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .bit_in(wire_bit),
        .wid(wid), .poly(poly), .state(state)
    );

    // R7: a rising enable leaves a zero result.
    assert_en_rise_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_en && !en_q) |=> (rd_data == '0));
    // R9: strobes are ignored while disabled.
    assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_en && !soft_clr) |=> $stable(rd_data));
    // R8: unsupported frame sizes freeze the result.
    assert_bad_len_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_len_m1 != 4'd7 && frm_len_m1 != 4'd15 && !clr) |=> $stable(rd_data));
    // R4: the upper half of the read word is zero.
    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(crc_en) |=> (rd_data[RD_W-1:CRC_W] == '0));
endmodule

// File: tb/spi_tx_crc_acc_test.sv
module spi_tx_crc_acc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crc_en = 1'b0;
    logic        soft_clr = 1'b0;
    logic        bit_vld = 1'b0;
    logic [15:0] frm_word = '0;
    logic [3:0]  frm_len_m1 = 4'd7;
    logic        lsb_first = 1'b0;
    logic [15:0] poly = 16'h0007;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_crc = '0;
    int          m_pos = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    spi_tx_crc_acc uut (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .soft_clr(soft_clr),
        .bit_vld(bit_vld), .frm_word(frm_word), .frm_len_m1(frm_len_m1),
        .lsb_first(lsb_first), .poly(poly), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] mstep(logic [15:0] c, logic b, logic w16, logic [15:0] p);
        logic f;
        if (w16) begin
            f = b ^ c[15];
            return (c << 1) ^ (f ? p : 16'h0);
        end
        f = b ^ c[7];
        return ((c << 1) ^ (f ? p : 16'h0)) & 16'h00FF;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expectation per accepted bit, 2 ns after the edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(rd_data === e, t, rd_data, e);
        end
    end

    // Driver: shifts n bits of a word, pushing the model result per bit (R5, R6).
    task automatic send_bits(input logic [15:0] w, input int n, input string tag);
        logic w16;
        int len;
        int idx;
        w16 = (frm_len_m1 == 4'd15);
        len = w16 ? 16 : 8;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frm_word = w;
            bit_vld  = 1'b1;
            idx = lsb_first ? m_pos : (len - 1 - m_pos);
            m_crc = mstep(m_crc, w[idx], w16, poly);
            m_pos = (m_pos == len - 1) ? 0 : m_pos + 1;
            exp_q.push_back({16'h0, m_crc});
            tag_q.push_back(tag);
        end
        @(negedge clk);
        bit_vld = 1'b0;
        wait (exp_q.size() == 0);
    endtask

    task automatic do_soft_clr;
        @(negedge clk);
        soft_clr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0;
        m_crc = '0;
        m_pos = 0;
    endtask

    initial begin
        logic [31:0] held;
        logic [31:0] r_msb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 32'h0, "R1 reset value", rd_data, 32'h0);

        crc_en = 1'b1;
        @(negedge clk);
        chk(rd_data == 32'h0, "R7 enable rise clear", rd_data, 32'h0);

        // R2 and R6: 8-bit frames, MSB-first then LSB-first, random data
        frm_len_m1 = 4'd7;
        for (int f = 0; f < 4; f++) send_bits(16'($urandom), 8, "R2 crc8 msb");
        chk(rd_data[15:8] == 8'h0, "R2 upper byte zero", rd_data, {24'h0, rd_data[7:0]});
        lsb_first = 1'b1;
        for (int f = 0; f < 4; f++) send_bits(16'($urandom), 8, "R6 crc8 lsb");

        // R3: 16-bit frames with polynomial 0x8005, both orders
        do_soft_clr();
        chk(rd_data == 32'h0, "R7 soft clear", rd_data, 32'h0);
        frm_len_m1 = 4'd15;
        poly = 16'h8005;
        for (int f = 0; f < 4; f++) send_bits(16'($urandom), 16, "R3 crc16 lsb");
        lsb_first = 1'b0;
        for (int f = 0; f < 4; f++) send_bits(16'($urandom), 16, "R3 crc16 msb");
        chk(rd_data[31:16] == 16'h0, "R4 upper half zero", rd_data, {16'h0, rd_data[15:0]});

        // R6: same word in the two orders gives different CRCs
        poly = 16'h0007;
        frm_len_m1 = 4'd7;
        do_soft_clr();
        send_bits(16'h0001, 8, "R6 order msb");
        r_msb = rd_data;
        do_soft_clr();
        lsb_first = 1'b1;
        send_bits(16'h0001, 8, "R6 order lsb");
        chk(rd_data != r_msb, "R6 orders differ", rd_data, r_msb);

        // R7: re-enable mid-frame clears CRC and position
        lsb_first = 1'b0;
        send_bits(16'h00A5, 5, "R5 partial frame");
        @(negedge clk);
        crc_en = 1'b0;
        @(negedge clk);
        crc_en = 1'b1;
        m_crc = '0;
        m_pos = 0;
        @(negedge clk);
        chk(rd_data == 32'h0, "R7 re-enable clear", rd_data, 32'h0);
        send_bits(16'h003C, 8, "R7 restart at first bit");

        // R8: unsupported frame length holds the value
        held = rd_data;
        frm_len_m1 = 4'd11;
        @(negedge clk);
        bit_vld = 1'b1;
        frm_word = 16'hFFFF;
        repeat (6) @(negedge clk);
        bit_vld = 1'b0;
        @(negedge clk);
        chk(rd_data == held, "R8 hold on bad length", rd_data, held);

        // R9: strobes ignored while disabled
        frm_len_m1 = 4'd7;
        crc_en = 1'b0;
        @(negedge clk);
        bit_vld = 1'b1;
        repeat (6) @(negedge clk);
        bit_vld = 1'b0;
        @(negedge clk);
        chk(rd_data == held, "R9 ignore while disabled", rd_data, held);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=%h exp=%h", rd_data, 32'h0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule